// File: doc/BRIEF.md
# Windowed Watchdog Timer Core

This block watches for software that has stopped servicing it. A 30-bit counter advances on a count-enable strobe. The strobe is produced outside the block from whichever clock source the mode selects. Software must write the service code before the count reaches a timeout of 2^(15+2·P) strobes. If it does not, the block raises either a one-cycle interrupt or a one-cycle reset request, depending on the configured action.

A service window can be set so that servicing counts only late in the period. In that case a service that comes too early is itself a fault. In reset mode an early service resets the block immediately. In interrupt mode it raises the interrupt and a sticky flag, and counting continues. Stopping the block takes two steps: software clears the enable bit, then writes the stop code. Mode fields are accepted only while the block is stopped. The count can be frozen by a debug-halt input, and it is visible at all times on a monitor output.

Top module: `wwdt_core`

## Requirements
- R1: After `rst`, the block is running (`running`=1) and the count is 0. `irq`, `rst_req` and `early_flag` are 0. The mode is: reset action, no window, P=0, clock select 00.
- R2: While running, `count_mon` rises by exactly one on each cycle with `tick` high, unless some other requirement clears it in that cycle.
- R3: A command write of 0x4E clears the count to 0 when the window allows it. Command values other than 0x4E and 0xB1 have no effect.
- R4: A write of 0xB1 while the enable bit is 0 stops the block and clears the count (`running`=0). A write of 0xB1 while the enable bit is 1 is ignored. Writing 1 to the enable bit makes the block run again.
- R5: The timeout is 2^(15+2·P) strobes, where P is the 3-bit `mode_tmo_sel`. In interrupt mode, the strobe that reaches the timeout gives a one-cycle `irq` on the next cycle, and the count restarts at 0.
- R6: Window codes on `mode_window` are: 00 service at any time; 01 only when count ≥ timeout/2; 10 only when count ≥ 3/4 of the timeout; 11 behaves like 00.
- R7: In interrupt mode (`mode_rst_act`=0), a service before the window pulses `irq` and sets `early_flag`. The count is not cleared.
- R8: In reset mode (`mode_rst_act`=1), either an early service or a timeout gives a one-cycle `rst_req` on the next cycle and returns the block to its R1 state.
- R9: `early_flag` is cleared by a mode write with `mode_flag_clr`=1. A mode write with 0 there leaves the flag unchanged.
- R10: Mode fields load only while the block is stopped. A mode write while running leaves them unchanged.
- R11: While `dbg_halt` is high, the count holds its value.
- R12: `clk_sel` presents the stored clock-select field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-enable strobe from the selected source |
| dbg_halt | input | 1 | Freeze the count |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command code (0x4E service, 0xB1 stop) |
| en_wr | input | 1 | Enable-bit write strobe |
| en_val | input | 1 | Enable-bit value |
| mode_wr | input | 1 | Mode write strobe |
| mode_clk_sel | input | 2 | Clock-source select field |
| mode_tmo_sel | input | 3 | Timeout select P |
| mode_window | input | 2 | Window code |
| mode_rst_act | input | 1 | 1 = reset on fault, 0 = interrupt |
| mode_flag_clr | input | 1 | 1 clears the early-service flag |
| clk_sel | output | 2 | Stored clock-select field |
| irq | output | 1 | One-cycle interrupt pulse |
| rst_req | output | 1 | One-cycle reset request |
| early_flag | output | 1 | Sticky early-service flag |
| running | output | 1 | 1 while counting, 0 once stopped |
| count_mon | output | 30 | Count monitor |

## Verification
Some properties are checked by assertions on every cycle:
- the count stays below the selected timeout;
- the count holds under debug halt;
- a reset request leaves the block counting from 0;
- a stop leaves the count at 0;
- a stopped block always has its enable bit low;
- a rising early flag comes with an interrupt.

Other behaviour can only be shown by the bench's scenarios:
- the exact window thresholds at their boundary counts;
- the timeout length for different selects;
- that stray command codes and mode writes while running are ignored;
- the restoration of the default mode after a fault reset.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;

    localparam int CNT_W    = 30;
    localparam int SEL_W    = 3;
    localparam int CSEL_W   = 2;
    localparam int BASE_EXP = 15;
    localparam int EXP_STEP = 2;

    localparam logic [7:0] SVC_CODE  = 8'h4E;
    localparam logic [7:0] STOP_CODE = 8'hB1;

    typedef enum logic [1:0] {
        WIN_ANY     = 2'b00,
        WIN_HALF    = 2'b01,
        WIN_QUARTER = 2'b10,
        WIN_RSVD    = 2'b11
    } win_e;

    typedef struct packed {
        logic [CSEL_W-1:0] clk_sel;
        logic [SEL_W-1:0]  tmo_sel;
        win_e              win;
        logic              rst_act;
    } mode_t;

    localparam mode_t MODE_DEFAULT = '{clk_sel: '0, tmo_sel: '0, win: WIN_ANY, rst_act: 1'b1};

    function automatic logic [CNT_W-1:0] limit_of(input logic [SEL_W-1:0] sel);
        logic [CNT_W-1:0] one;
        one = {{(CNT_W-1){1'b0}}, 1'b1};
        return one << (BASE_EXP + EXP_STEP * int'(sel));
    endfunction

    function automatic logic window_open(input logic [CNT_W-1:0] cnt,
                                         input logic [CNT_W-1:0] lim,
                                         input win_e win);
        case (win)
            WIN_HALF:    return cnt >= (lim >> 1);
            WIN_QUARTER: return cnt >= (lim - (lim >> 2));
            default:     return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/wwdt_ctrl.sv
module wwdt_ctrl
    import wwdt_pkg::*;
(
    input  logic  clk,
    input  logic  srst,
    input  logic  en_wr,
    input  logic  en_val,
    input  logic  stop_ev,
    input  logic  mode_wr,
    input  mode_t mode_in,
    input  logic  flag_clr,
    input  logic  early_irq,
    output logic  en_bit,
    output logic  running,
    output mode_t mode_q,
    output logic  early_flag
);

    always_ff @(posedge clk) begin
        if (srst) begin
            en_bit     <= 1'b1;
            running    <= 1'b1;
            mode_q     <= MODE_DEFAULT;
            early_flag <= 1'b0;
        end else begin
            if (en_wr) begin
                en_bit <= en_val;
                if (en_val) running <= 1'b1;
            end
            if (stop_ev) running <= 1'b0;
            if (mode_wr && !running) mode_q <= mode_in;
            if (early_irq)
                early_flag <= 1'b1;
            else if (mode_wr && flag_clr)
                early_flag <= 1'b0;
        end
    end

    // R4
    stopped_needs_en_low_chk: assert property (@(posedge clk) disable iff (srst)
        !running |-> !en_bit);

endmodule

// File: rtl/wwdt_counter.sv
module wwdt_counter
    import wwdt_pkg::*;
(
    input  logic             clk,
    input  logic             srst,
    input  logic             clr,
    input  logic             tick_go,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             at_end
);

    assign at_end = (cnt == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (srst || clr)
            cnt <= '0;
        else if (tick_go)
            cnt <= cnt + 1'b1;
    end

    // R5
    below_limit_chk: assert property (@(posedge clk) disable iff (srst)
        cnt < limit);

endmodule

// File: rtl/wwdt_core.sv
module wwdt_core
    import wwdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              dbg_halt,
    input  logic              cmd_wr,
    input  logic [7:0]        cmd_data,
    input  logic              en_wr,
    input  logic              en_val,
    input  logic              mode_wr,
    input  logic [CSEL_W-1:0] mode_clk_sel,
    input  logic [SEL_W-1:0]  mode_tmo_sel,
    input  logic [1:0]        mode_window,
    input  logic              mode_rst_act,
    input  logic              mode_flag_clr,
    output logic [CSEL_W-1:0] clk_sel,
    output logic              irq,
    output logic              rst_req,
    output logic              early_flag,
    output logic              running,
    output logic [CNT_W-1:0]  count_mon
);

    mode_t            mode_q;
    mode_t            mode_in;
    logic             en_bit;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic             at_end;
    logic             svc, win_ok, early, stop_ev, tick_go, tmo;
    logic             fault_rst, irq_ev, srst, cnt_clr;

    assign mode_in = '{clk_sel: mode_clk_sel, tmo_sel: mode_tmo_sel,
                       win: win_e'(mode_window), rst_act: mode_rst_act};
    assign limit   = limit_of(mode_q.tmo_sel);

    assign svc       = running && cmd_wr && (cmd_data == SVC_CODE);
    assign stop_ev   = running && cmd_wr && (cmd_data == STOP_CODE) && !en_bit;
    assign win_ok    = window_open(cnt, limit, mode_q.win);
    assign early     = svc && !win_ok;
    assign tick_go   = running && tick && !dbg_halt;
    assign tmo       = tick_go && at_end && !(svc && win_ok);
    assign fault_rst = mode_q.rst_act && (early || tmo);
    assign irq_ev    = !mode_q.rst_act && (early || tmo);
    assign srst      = rst || fault_rst;
    assign cnt_clr   = stop_ev || (svc && win_ok) || (tmo && !mode_q.rst_act);

    wwdt_ctrl u_ctrl (
        .clk        (clk),
        .srst       (srst),
        .en_wr      (en_wr),
        .en_val     (en_val),
        .stop_ev    (stop_ev),
        .mode_wr    (mode_wr),
        .mode_in    (mode_in),
        .flag_clr   (mode_flag_clr),
        .early_irq  (early && !mode_q.rst_act),
        .en_bit     (en_bit),
        .running    (running),
        .mode_q     (mode_q),
        .early_flag (early_flag)
    );

    wwdt_counter u_cnt (
        .clk     (clk),
        .srst    (srst),
        .clr     (cnt_clr),
        .tick_go (tick_go),
        .limit   (limit),
        .cnt     (cnt),
        .at_end  (at_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq     <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            irq     <= irq_ev;
            rst_req <= fault_rst;
        end
    end

    assign clk_sel   = mode_q.clk_sel;
    assign count_mon = cnt;

    // R8
    fault_reinit_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (count_mon == '0) && running && mode_q.rst_act);

    // R4
    stop_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(running) |-> (count_mon == '0));

    // R7
    flag_with_irq_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(early_flag) |-> irq);

    // R11
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_halt && !cmd_wr) |=> $stable(count_mon));

endmodule

// File: tb/test_wwdt_core.sv
module test_wwdt_core;
    import wwdt_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick = 1'b1;
    logic              dbg_halt = 1'b0;
    logic              cmd_wr = 1'b0;
    logic [7:0]        cmd_data = 8'h00;
    logic              en_wr = 1'b0;
    logic              en_val = 1'b0;
    logic              mode_wr = 1'b0;
    logic [1:0]        mode_clk_sel = '0;
    logic [2:0]        mode_tmo_sel = '0;
    logic [1:0]        mode_window = '0;
    logic              mode_rst_act = 1'b0;
    logic              mode_flag_clr = 1'b0;
    logic [1:0]        clk_sel;
    logic              irq, rst_req, early_flag, running;
    logic [CNT_W-1:0]  count_mon;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    wwdt_core i_wwdt_core (
        .clk(clk), .rst(rst), .tick(tick), .dbg_halt(dbg_halt),
        .cmd_wr(cmd_wr), .cmd_data(cmd_data), .en_wr(en_wr), .en_val(en_val),
        .mode_wr(mode_wr), .mode_clk_sel(mode_clk_sel), .mode_tmo_sel(mode_tmo_sel),
        .mode_window(mode_window), .mode_rst_act(mode_rst_act),
        .mode_flag_clr(mode_flag_clr), .clk_sel(clk_sel), .irq(irq),
        .rst_req(rst_req), .early_flag(early_flag), .running(running),
        .count_mon(count_mon)
    );

    // code in [8:1], 1 in bit 0 when the code must clear the count
    localparam logic [8:0] VEC [7] = '{
        {8'h4E, 1'b1}, {8'h00, 1'b0}, {8'hB1, 1'b0}, {8'hFF, 1'b0},
        {8'h4F, 1'b0}, {8'hE4, 1'b0}, {8'h4E, 1'b1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cmd(input logic [7:0] d);
        cmd_data = d; cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic wait_cnt(input logic [CNT_W-1:0] v);
        while (count_mon != v) @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] cs, input logic [2:0] p,
                            input logic [1:0] w, input logic ra, input logic fc);
        mode_clk_sel = cs; mode_tmo_sel = p; mode_window = w;
        mode_rst_act = ra; mode_flag_clr = fc; mode_wr = 1'b1;
        @(negedge clk);
        mode_wr = 1'b0; mode_flag_clr = 1'b0;
    endtask

    task automatic stop_blk();
        en_val = 1'b0; en_wr = 1'b1;
        @(negedge clk);
        en_wr = 1'b0;
        cmd(STOP_CODE);
    endtask

    task automatic start_blk();
        en_val = 1'b1; en_wr = 1'b1;
        @(negedge clk);
        en_wr = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [CNT_W-1:0] prev;
        logic             saw_irq;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 count", count_mon, 0);
        check("R1 running", running, 1);
        check("R1 irq/rst_req/flag", {irq, rst_req, early_flag}, 0);
        check("R12 clk_sel default", clk_sel, 0);
        // R2 counting
        repeat (7) @(negedge clk);
        check("R2 count after 7 strobes", count_mon, 7);

        // R3 command table, R4 stop code ignored while enabled
        for (int i = 0; i < 7; i++) begin
            repeat (4) @(negedge clk);
            prev = count_mon;
            cmd(VEC[i][8:1]);
            check("R3 table count", count_mon, VEC[i][0] ? 0 : prev + 1);
            check("R4 table running", running, 1);
            check("R3 table rst_req", rst_req, 0);
        end

        // R4 two-step stop
        en_val = 1'b0; en_wr = 1'b1;
        @(negedge clk);
        en_wr = 1'b0;
        check("R4 still running after enable=0", running, 1);
        cmd(STOP_CODE);
        check("R4 stopped", running, 0);
        check("R4 count cleared", count_mon, 0);
        repeat (5) @(negedge clk);
        check("R4 count held stopped", count_mon, 0);
        cmd(SVC_CODE);
        check("R4 service while stopped no irq", irq, 0);
        set_mode(2'b10, 3'd0, 2'b01, 1'b0, 1'b0);
        check("R12 clk_sel loaded", clk_sel, 2);
        start_blk();
        check("R4 resumed", running, 1);

        // R7 early service in interrupt mode
        wait_cnt(100);
        cmd(SVC_CODE);
        check("R7 irq", irq, 1);
        check("R7 flag", early_flag, 1);
        check("R7 count kept", count_mon, 101);
        @(negedge clk);
        check("R7 irq one cycle", irq, 0);
        // R9 flag clear
        set_mode(2'b00, 3'd0, 2'b00, 1'b0, 1'b0);
        check("R9 flag kept with clr=0", early_flag, 1);
        set_mode(2'b00, 3'd0, 2'b00, 1'b1, 1'b1);
        check("R9 flag cleared", early_flag, 0);
        check("R10 clk_sel unchanged while running", clk_sel, 2);

        // R6 half window boundary
        wait_cnt(16383);
        cmd(SVC_CODE);
        check("R6 half early irq", irq, 1);
        check("R6 half early count", count_mon, 16384);
        cmd(SVC_CODE);
        check("R6 half in-window clear", count_mon, 0);
        check("R6 half in-window no irq", irq, 0);

        // R5 timeout in interrupt mode
        wait_cnt(32767);
        @(negedge clk);
        check("R5 timeout irq", irq, 1);
        check("R5 timeout restart", count_mon, 0);
        @(negedge clk);
        check("R5 irq pulse ends", irq, 0);
        check("R5 count after restart", count_mon, 1);

        // R6 quarter window boundary
        stop_blk();
        set_mode(2'b00, 3'd0, 2'b10, 1'b0, 1'b1);
        start_blk();
        wait_cnt(24575);
        cmd(SVC_CODE);
        check("R6 quarter early irq", irq, 1);
        check("R6 quarter early count", count_mon, 24576);
        cmd(SVC_CODE);
        check("R6 quarter clear", count_mon, 0);

        // R6 reserved window code behaves as any time
        stop_blk();
        set_mode(2'b00, 3'd0, 2'b11, 1'b0, 1'b1);
        start_blk();
        wait_cnt(10);
        cmd(SVC_CODE);
        check("R6 reserved clear", count_mon, 0);
        check("R6 reserved no irq", irq, 0);

        // R8 reset mode early service
        stop_blk();
        set_mode(2'b01, 3'd0, 2'b01, 1'b1, 1'b1);
        check("R12 clk_sel 01", clk_sel, 1);
        start_blk();
        wait_cnt(50);
        cmd(SVC_CODE);
        check("R8 rst_req", rst_req, 1);
        check("R8 count reinit", count_mon, 0);
        check("R8 running reinit", running, 1);
        check("R8 clk_sel reinit", clk_sel, 0);
        check("R8 no irq", irq, 0);
        @(negedge clk);
        check("R8 rst_req pulse ends", rst_req, 0);
        wait_cnt(5);
        cmd(SVC_CODE);
        check("R8 window default after fault", count_mon, 0);
        check("R8 no fault in default window", rst_req, 0);
        // R8 timeout in reset mode
        wait_cnt(32767);
        @(negedge clk);
        check("R8 timeout rst_req", rst_req, 1);
        check("R8 timeout count", count_mon, 0);

        // R11 debug halt
        wait_cnt(20);
        dbg_halt = 1'b1;
        repeat (10) @(negedge clk);
        check("R11 count held", count_mon, 20);
        dbg_halt = 1'b0;
        @(negedge clk);
        check("R11 count resumes", count_mon, 21);

        // R5 longer select: no timeout at 2^15
        stop_blk();
        set_mode(2'b11, 3'd1, 2'b00, 1'b0, 1'b1);
        start_blk();
        saw_irq = 1'b0;
        while (count_mon != 32770) begin
            @(negedge clk);
            if (irq) saw_irq = 1'b1;
        end
        check("R5 P=1 no early timeout", saw_irq, 0);
        // R10 mode write while running is ignored
        set_mode(2'b00, 3'd0, 2'b01, 1'b1, 1'b0);
        check("R10 clk_sel kept", clk_sel, 3);
        cmd(SVC_CODE);
        check("R10 window unchanged clear", count_mon, 0);
        check("R10 action unchanged", {irq, rst_req}, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule